// File: doc/BRIEF.md
# Ranked Port Scheduler with Dependent Wake-Up

This block sits beside the input queues of a coherence directory controller. Six input ports have fixed ranks from 0 (lowest) to 5 (highest): 5 is the internal trigger queue, 4 is unblocks, 3 is responses, 2 is memory replies, 1 is processor requests and 0 is DMA requests. Each cycle the block grants service to the highest-rank port that holds a valid message, and it reports the rank of that port. The controller's protocol logic then acts on the granted message. It may report a stall, meaning the message must wait on its line address. It may instead report that the message completed a blocking transaction on an address, and so its dependents should be woken.

The block keeps a small table of waiting addresses. Each entry holds one slot per rank, and a slot records that the port of that rank parked a message on the entry's address. A wake-up raised while a port of rank r is serviced releases only the waiting ports of rank strictly lower than r. The releases come out one per cycle as pulses, highest rank first. The whole entry is then discarded, including any slots at or above r. The message queues and the protocol transitions live outside the block.

Top module: `rank_wake_sched`

## Requirements
- R1: `svc_port` is the one-hot code of the highest-index set bit of `port_valid`, and `svc_rank` is that bit's index. Both are zero when no port is valid. The grant is combinational.
- R2: An accepted stall sets the slot of the serviced rank in the entry for `stall_addr`. If no entry exists for that address, a new entry is opened with every other slot clear.
- R3: A wake-up for an address that has no entry produces no release.
- R4: A wake-up releases exactly the occupied slots whose rank is strictly below the serviced rank, and each of those once.
- R5: Releases are single-cycle pulses on `rel_vld`/`rel_port`, one port per cycle, in strictly descending rank. The first pulse appears in the cycle after the wake-up is registered, and every pulse carries the woken address on `rel_addr`.
- R6: A wake-up that finds its entry frees the entry whole, including slots at or above the serviced rank. A later wake-up on that address releases nothing.
- R7: The table holds `E` entries (default 8). A stall that needs a new entry while all entries are in use is dropped, and `err` pulses high for one cycle in the cycle after it. A stall onto an address that already has an entry is still recorded while the table is full.
- R8: Stall and wake events are ignored when no port is valid. A wake-up raised while `rel_vld` is high is ignored and leaves the table unchanged.
- R9: When an accepted stall and an accepted wake-up name the same address in the same cycle, the wake-up is applied first. The stall then opens a fresh entry that holds only the serviced rank.
- R10: After reset, the table is empty, `rel_vld`, `rel_port` and `err` are low, and no release is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_valid | input | R (6) | Per-rank message-present flags; bit k is the port of rank k |
| stall_vld | input | 1 | The serviced message parks on `stall_addr` |
| stall_addr | input | AW (8) | Line address of the stall |
| wake_vld | input | 1 | The serviced message completed a transaction on `wake_addr` |
| wake_addr | input | AW (8) | Line address whose dependents are woken |
| svc_port | output | R (6) | One-hot grant to the highest-rank valid port |
| svc_rank | output | 3 | Index of the granted port (current rank) |
| rel_vld | output | 1 | A release pulse is present this cycle |
| rel_port | output | R (6) | One-hot port receiving the release |
| rel_addr | output | AW (8) | Address being released |
| err | output | 1 | One-cycle pulse: a stall was dropped because the table was full |

## Verification
The two functions that can coincide are the wake-up scan and the stall recording. They can hit the same address in one cycle, and a wake-up can also arrive while an earlier release burst is still draining. The bench raises a stall at rank 3 together with a wake-up on the same address that already holds a rank-0 waiter. It expects a single rank-0 release, and a later top-rank wake-up must then yield only rank 3. The bench also raises a second wake-up during a three-pulse burst. It judges that second wake-up by whether the burst continues unchanged and whether the second address still releases its waiter later.

// File: rtl/rws_pkg.sv
package rws_pkg;
    localparam int NUM_RANKS = 6;

    // Fixed port ranks; higher value is served first.
    typedef enum logic [2:0] {
        RK_DMA   = 3'd0,
        RK_REQ   = 3'd1,
        RK_MEM   = 3'd2,
        RK_RSP   = 3'd3,
        RK_UNBLK = 3'd4,
        RK_TRIG  = 3'd5
    } rank_e;
endpackage

// File: rtl/rws_pick.sv
// Highest-index set bit to one-hot.
module rws_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] oh
);
    always_comb begin
        oh = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k]) begin
                oh    = '0;
                oh[k] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rws_cam.sv
// Associative lookup of a key among valid table tags.
module rws_cam #(
    parameter int E  = 8,
    parameter int AW = 8,
    localparam int EW = (E > 1) ? $clog2(E) : 1
) (
    input  logic [E-1:0]         vld,
    input  logic [E-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    output logic                 hit,
    output logic [EW-1:0]        idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < E; k++) begin
            if (vld[k] && tags[k] == key) begin
                hit = 1'b1;
                idx = EW'(k);
            end
        end
    end
endmodule

// File: rtl/rank_wake_sched.sv
module rank_wake_sched
    import rws_pkg::*;
#(
    parameter int R  = NUM_RANKS,
    parameter int AW = 8,
    parameter int E  = 8,
    localparam int RW = (R > 1) ? $clog2(R) : 1,
    localparam int EW = (E > 1) ? $clog2(E) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [R-1:0]  port_valid,
    input  logic          stall_vld,
    input  logic [AW-1:0] stall_addr,
    input  logic          wake_vld,
    input  logic [AW-1:0] wake_addr,
    output logic [R-1:0]  svc_port,
    output logic [RW-1:0] svc_rank,
    output logic          rel_vld,
    output logic [R-1:0]  rel_port,
    output logic [AW-1:0] rel_addr,
    output logic          err
);
    typedef struct packed {
        logic [E-1:0]         v;
        logic [E-1:0][AW-1:0] tag;
        logic [E-1:0][R-1:0]  slot;
        logic [R-1:0]         pend;
        logic [AW-1:0]        paddr;
        logic                 err;
    } st_t;

    st_t st_d, st_q;

    logic [R-1:0]  svc_oh, rel_oh, below;
    logic          svc_any, busy, wake_acc, stall_acc;
    logic          w_hit, s_hit, f_any;
    logic [EW-1:0] w_idx, s_idx, f_idx;
    logic [E-1:0]  wake_kill, v_mid;

    rws_pick #(.N(R)) u_svc_pick (.req(port_valid), .oh(svc_oh));
    rws_pick #(.N(R)) u_rel_pick (.req(st_q.pend), .oh(rel_oh));

    // Current rank and the mask of ranks strictly below it.
    always_comb begin
        svc_rank = '0;
        for (int k = 0; k < R; k++) begin
            if (svc_oh[k]) svc_rank = RW'(k);
        end
        for (int k = 0; k < R; k++) begin
            below[k] = (RW'(k) < svc_rank);
        end
    end

    assign svc_any   = |port_valid;
    assign busy      = |st_q.pend;
    assign wake_acc  = wake_vld & svc_any & ~busy;
    assign stall_acc = stall_vld & svc_any;

    rws_cam #(.E(E), .AW(AW)) u_wake_cam (
        .vld(st_q.v), .tags(st_q.tag), .key(wake_addr), .hit(w_hit), .idx(w_idx)
    );

    assign wake_kill = (wake_acc && w_hit) ? (E'(1) << w_idx) : '0;
    assign v_mid     = st_q.v & ~wake_kill;

    // Stall lookup sees the table after this cycle's wake-up.
    rws_cam #(.E(E), .AW(AW)) u_stall_cam (
        .vld(v_mid), .tags(st_q.tag), .key(stall_addr), .hit(s_hit), .idx(s_idx)
    );

    always_comb begin
        f_any = 1'b0;
        f_idx = '0;
        for (int k = E - 1; k >= 0; k--) begin
            if (!v_mid[k]) begin
                f_any = 1'b1;
                f_idx = EW'(k);
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        st_d.pend = st_q.pend & ~rel_oh;
        if (wake_acc && w_hit) begin
            st_d.pend       = st_q.slot[w_idx] & below;
            st_d.paddr      = wake_addr;
            st_d.v[w_idx]   = 1'b0;
        end
        if (stall_acc) begin
            if (s_hit) begin
                st_d.slot[s_idx][svc_rank] = 1'b1;
            end else if (f_any) begin
                st_d.v[f_idx]              = 1'b1;
                st_d.tag[f_idx]            = stall_addr;
                st_d.slot[f_idx]           = '0;
                st_d.slot[f_idx][svc_rank] = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign svc_port = svc_oh;
    assign rel_vld  = busy;
    assign rel_port = rel_oh;
    assign rel_addr = st_q.paddr;
    assign err      = st_q.err;
endmodule

// File: rtl/rws_chk.sv
module rws_chk #(
    parameter int R  = 6,
    parameter int AW = 8,
    parameter int RW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [R-1:0]  port_valid,
    input logic          stall_vld,
    input logic          wake_vld,
    input logic [R-1:0]  svc_port,
    input logic [RW-1:0] svc_rank,
    input logic          rel_vld,
    input logic [R-1:0]  rel_port,
    input logic [AW-1:0] rel_addr,
    input logic          err
);
    logic [RW-1:0] last_rank_q;
    logic [R:0]    lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_rank_q <= '0;
        else if (wake_vld && |port_valid && !rel_vld) last_rank_q <= svc_rank;
    end
    assign lim = (R+1)'(1) << last_rank_q;

    AST_GRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_port) && ((|port_valid) == (|svc_port)));            // R1
    AST_REL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld == ($countones(rel_port) == 1));                          // R5
    AST_REL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld |-> ({1'b0, rel_port} < lim));                            // R4
    AST_REL_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld && $past(rel_vld) |-> (rel_port < $past(rel_port)) && $stable(rel_addr)); // R5
    AST_REL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld && !$past(rel_vld) |-> $past(wake_vld && |port_valid));   // R8
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(stall_vld && |port_valid));                         // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err || $past(stall_vld && |port_valid));                 // R7
endmodule

bind rank_wake_sched rws_chk #(.R(R), .AW(AW), .RW(RW)) u_rws_chk (
    .clk(clk), .rst_n(rst_n), .port_valid(port_valid), .stall_vld(stall_vld),
    .wake_vld(wake_vld), .svc_port(svc_port), .svc_rank(svc_rank),
    .rel_vld(rel_vld), .rel_port(rel_port), .rel_addr(rel_addr), .err(err)
);

// File: tb/test_rank_wake_sched.sv
`timescale 1ns/1ps
module test_rank_wake_sched;
    import rws_pkg::*;
    localparam int R = 6;
    localparam int AW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [R-1:0] port_valid = '0;
    logic stall_vld = 1'b0, wake_vld = 1'b0;
    logic [AW-1:0] stall_addr = '0, wake_addr = '0;
    logic [R-1:0] svc_port, rel_port;
    logic [2:0] svc_rank;
    logic rel_vld, err;
    logic [AW-1:0] rel_addr;
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    rank_wake_sched i_rank_wake_sched (
        .clk(clk), .rst_n(rst_n), .port_valid(port_valid),
        .stall_vld(stall_vld), .stall_addr(stall_addr),
        .wake_vld(wake_vld), .wake_addr(wake_addr),
        .svc_port(svc_port), .svc_rank(svc_rank),
        .rel_vld(rel_vld), .rel_port(rel_port), .rel_addr(rel_addr), .err(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_stall(input int r, input logic [AW-1:0] a, input bit exp_err, input string req);
        @(negedge clk);
        port_valid = R'(1 << r); stall_vld = 1'b1; stall_addr = a;
        @(negedge clk);
        port_valid = '0; stall_vld = 1'b0;
        check(err == exp_err, req, int'(err), int'(exp_err));
    endtask

    // Raise a wake-up at rank r, then expect one pulse per set bit of exp, top down.
    task automatic do_wake(input int r, input logic [AW-1:0] a, input logic [R-1:0] exp, input string req);
        @(negedge clk);
        port_valid = R'(1 << r); wake_vld = 1'b1; wake_addr = a;
        @(negedge clk);
        port_valid = '0; wake_vld = 1'b0;
        for (int k = R - 1; k >= 0; k--) begin
            if (exp[k]) begin
                check(rel_vld && rel_port == R'(1 << k) && rel_addr == a, req,
                      int'({rel_vld, rel_port, rel_addr}), int'({1'b1, R'(1 << k), a}));
                @(negedge clk);
            end
        end
        check(!rel_vld, req, int'(rel_vld), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!rel_vld && rel_port == '0 && !err, "R10", int'({rel_vld, rel_port, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rel_vld && !err, "R10", int'({rel_vld, err}), 0);

        // R1: grant sweep over every valid pattern
        for (int v = 0; v < 64; v++) begin
            int hi;
            hi = -1;
            for (int k = 0; k < R; k++) if (v[k]) hi = k;
            port_valid = R'(v);
            #1;
            check(svc_port == ((hi < 0) ? R'(0) : R'(1 << hi)), "R1", int'(svc_port), (hi < 0) ? 0 : (1 << hi));
            check(int'(svc_rank) == ((hi < 0) ? 0 : hi), "R1", int'(svc_rank), (hi < 0) ? 0 : hi);
        end
        @(negedge clk);
        port_valid = '0;

        // R2 R3 R4 R5 R6: every slot pattern against every wake rank
        for (int r = 0; r < R; r++) begin
            for (int m = 0; m < 64; m++) begin
                for (int k = 0; k < R; k++) if (m[k]) do_stall(k, 8'h55, 1'b0, "R2");
                do_wake(r, 8'h55, R'(m) & R'((1 << r) - 1), (m == 0) ? "R3" : "R4");
                do_wake(int'(RK_TRIG), 8'h55, '0, "R6");
            end
        end

        // R7: fill the table, overflow, then stall onto an existing address
        for (int i = 0; i < 8; i++) do_stall(1, AW'(8'h10 + i), 1'b0, "R7");
        do_stall(1, 8'h20, 1'b1, "R7");
        @(negedge clk);
        check(!err, "R7", int'(err), 0);
        do_stall(2, 8'h10, 1'b0, "R7");
        do_wake(5, 8'h20, '0, "R7");
        do_wake(5, 8'h10, 6'b000110, "R7");
        for (int i = 1; i < 8; i++) do_wake(5, AW'(8'h10 + i), 6'b000010, "R7");
        do_stall(1, 8'h20, 1'b0, "R7");
        do_wake(5, 8'h20, 6'b000010, "R7");

        // R8: events with no valid port are ignored
        @(negedge clk);
        stall_vld = 1'b1; stall_addr = 8'h50;
        @(negedge clk);
        stall_vld = 1'b0;
        do_wake(5, 8'h50, '0, "R8");
        do_stall(0, 8'h51, 1'b0, "R8");
        @(negedge clk);
        wake_vld = 1'b1; wake_addr = 8'h51;
        @(negedge clk);
        wake_vld = 1'b0;
        check(!rel_vld, "R8", int'(rel_vld), 0);
        do_wake(5, 8'h51, 6'b000001, "R8");

        // R8: wake-up during a release burst is ignored
        do_stall(0, 8'h30, 1'b0, "R8");
        do_stall(1, 8'h30, 1'b0, "R8");
        do_stall(2, 8'h30, 1'b0, "R8");
        do_stall(0, 8'h31, 1'b0, "R8");
        @(negedge clk);
        port_valid = 6'b100000; wake_vld = 1'b1; wake_addr = 8'h30;
        @(negedge clk);
        wake_addr = 8'h31;
        check(rel_vld && rel_port == 6'b000100, "R8", int'(rel_port), 4);
        @(negedge clk);
        port_valid = '0; wake_vld = 1'b0;
        check(rel_vld && rel_port == 6'b000010 && rel_addr == 8'h30, "R8", int'(rel_port), 2);
        @(negedge clk);
        check(rel_vld && rel_port == 6'b000001, "R8", int'(rel_port), 1);
        @(negedge clk);
        check(!rel_vld, "R8", int'(rel_vld), 0);
        do_wake(5, 8'h31, 6'b000001, "R8");

        // R9: same-cycle stall and wake-up on one address
        do_stall(0, 8'h40, 1'b0, "R9");
        @(negedge clk);
        port_valid = 6'b001000; stall_vld = 1'b1; stall_addr = 8'h40;
        wake_vld = 1'b1; wake_addr = 8'h40;
        @(negedge clk);
        port_valid = '0; stall_vld = 1'b0; wake_vld = 1'b0;
        check(rel_vld && rel_port == 6'b000001, "R9", int'(rel_port), 1);
        @(negedge clk);
        check(!rel_vld, "R9", int'(rel_vld), 0);
        do_wake(5, 8'h40, 6'b001000, "R9");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule